// File: doc/BRIEF.md
# TDM Network Serial Port

This block is a synchronous serial transmitter and receiver for a time-division-multiplexed network of codecs or processors. Each frame is cut into a configurable number of time slots. Every slot carries one data word of configurable length. Slot numbers count from the frame sync, so slot 0 is the word that starts on the bit after the sync. A frame therefore lasts the word length times the slot count, in bit periods.

Two 32-bit masks, one per direction, choose which slots the port serves. A slot whose mask bit is clear moves nothing through the FIFOs. Software therefore only deals with the slots it owns.

The port can run as frame master or as slave:
- As master it generates a one-bit-wide frame sync from its own slot and bit counters.
- As slave it locks onto an external sync.

Two-channel mode hands enabled slots alternately to FIFO 0 and FIFO 1, for example the left and right samples of a stereo codec. The alternation restarts at FIFO 0 with every frame.

The serial bit clock is modelled as a one-cycle enable on the system clock. The transmit word changes at the bit-enable that starts each bit. The receive bit is captured at the bit-enable that ends it.

Top module: `tdm_port`

## Requirements
- R1: The frame has `slots_m1+1` slots (2 to 32) of `wlen_m1+1` bits each. In master mode `fs_out` is high for exactly one bit period, the last bit of the last slot. The reset state counts as that bit, so the first `bit_en` after reset starts slot 0. In slave mode `fs_out` stays 0.
- R2: In slave mode, the bit after any `bit_en` that samples `fs_in` high is bit 0 of slot 0. Before the first such sample the port sends nothing (`sd_out_en` is 0) and stores no received word.
- R3: A transmitted word is the low `wlen_m1+1` bits of a FIFO entry. It goes out MSB first, one bit per bit period, and `sd_out_en` is high for the whole slot.
- R4: Bit s of `tx_slot_en` (s = slot number) enables transmit slot s. In a disabled slot `sd_out` and `sd_out_en` are 0, and no transmit FIFO entry is consumed.
- R5: A received word is the `wlen_m1+1` bits of `sd_in` captured at the bit-enables that end each bit of the slot, MSB first. It is stored right-justified with zero upper bits, and only when bit s of `rx_slot_en` is set.
- R6: With `two_chan` high, enabled slots alternate between channel 0 and channel 1, starting at channel 0 in slot 0 of every frame. Each direction alternates on its own. With `two_chan` low only channel 0 is used.
- R7: An enabled transmit slot whose FIFO is empty sends zeros with `sd_out_en` low and sets the sticky `tx_underflow`. A push in that same cycle does not rescue the slot; the pushed word waits for the next slot.
- R8: An enabled receive slot whose FIFO is full drops the word and sets the sticky `rx_overflow`. A pop in that same cycle does not make room.
- R9: Each FIFO holds 4 words and shows its oldest word on its read data. A push to a full FIFO is ignored, and so is a pop from an empty one.
- R10: Synchronous active-low reset empties all FIFOs and clears both sticky flags, `sd_out_en` and lock. Configuration is changed only while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse per serial bit period |
| master_mode | input | 1 | 1: generate frame sync, 0: follow `fs_in` |
| two_chan | input | 1 | Alternate enabled slots between two channels |
| slots_m1 | input | 5 | Slots per frame minus one (1 to 31) |
| wlen_m1 | input | 5 | Word length minus one |
| tx_slot_en | input | 32 | Transmit slot enables, bit s for slot s |
| rx_slot_en | input | 32 | Receive slot enables, bit s for slot s |
| fs_in | input | 1 | External frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode) |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| sd_out_en | output | 1 | High while a word is being sent |
| tx_push | input | 2 | Push strobe per transmit channel |
| tx_wdata | input | 64 | Push data, channel c in bits 32c+31..32c |
| tx_full | output | 2 | Transmit FIFO full, per channel |
| rx_pop | input | 2 | Pop strobe per receive channel |
| rx_rdata | output | 64 | Oldest received word, channel c in bits 32c+31..32c |
| rx_empty | output | 2 | Receive FIFO empty, per channel |
| tx_underflow | output | 1 | Sticky transmit underflow |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
The two collisions that matter are these:
- A slot start pulls from an empty transmit FIFO in the same cycle as a user push into it.
- A finished received word meets a full receive FIFO in the same cycle as a user pop.

The bench provokes the first collision on purpose. It pushes only in the bit-enable cycle that opens a slot, and only while its model queue is empty. It provokes the second by popping the receive FIFO rarely, so the FIFO sits full while pops still arrive.

Both collisions are judged against a behavioural model in which every decision uses the FIFO levels from before the edge. The model therefore expects the slot to underflow with the pushed word kept for later, and it expects the received word to be dropped while the pop still removes the oldest entry.

// File: rtl/tdm_pkg.sv
// Shared types for the TDM serial port.
// Assumes: exactly two channels, selected by a one-bit enum.
package tdm_pkg;

    typedef enum logic {
        CH_ZERO = 1'b0,
        CH_ONE  = 1'b1
    } tdm_ch_e;

    // Channel for the next enabled slot: flips after a served slot, holds otherwise.
    function automatic tdm_ch_e tdm_next_ch(input tdm_ch_e eff, input logic slot_on);
        if (slot_on) begin
            return (eff == CH_ZERO) ? CH_ONE : CH_ZERO;
        end
        return eff;
    endfunction

endpackage

// File: rtl/tdm_fifo.sv
// Small show-ahead FIFO: read data always shows the oldest entry.
// Assumes: a push when full and a pop when empty are dropped; the flags
// are judged on the level before the edge.
module tdm_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_q];

    // Storage write for accepted pushes.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= wdata;
        end
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            end
            if (do_pop) begin
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_full_push_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/tdm_timing.sv
// Frame position tracker: counts bits within a slot and slots within a frame.
// Master mode makes its own sync at the last bit of the frame; slave mode
// restarts at slot 0 after any bit that samples fs_in high.
// Assumes: slots_m1 and wlen_m1 are static outside reset.
module tdm_timing #(
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              master_mode,
    input  logic              fs_in,
    input  logic [SLOT_W-1:0] slots_m1,
    input  logic [BIT_W-1:0]  wlen_m1,
    output logic              fs_out,
    output logic              word_start,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] next_slot,
    output logic              locked,
    output logic              lock_next
);
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              locked_q;
    logic              frame_last, sync_bit;

    assign frame_last = (slot_q == slots_m1) && (bit_q == wlen_m1);
    assign sync_bit   = master_mode ? frame_last : fs_in;
    assign word_start = bit_en && (sync_bit || (bit_q == wlen_m1));
    assign next_slot  = (sync_bit || (slot_q == slots_m1)) ? '0 : slot_q + SLOT_W'(1);
    assign lock_next  = locked_q || sync_bit;
    assign fs_out     = master_mode && frame_last;
    assign cur_slot   = slot_q;
    assign locked     = locked_q;

    // Advance the bit/slot position once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q    <= wlen_m1;
            slot_q   <= slots_m1;
            locked_q <= 1'b0;
        end else if (bit_en) begin
            if (word_start) begin
                bit_q  <= '0;
                slot_q <= next_slot;
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
            if (sync_bit) begin
                locked_q <= 1'b1;
            end
        end
    end

    assert_fs_single_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && bit_en && fs_out) |=> !fs_out);

    assert_slot_zero_after_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && sync_bit) |=> (cur_slot == '0 && bit_q == '0));

endmodule

// File: rtl/tdm_tx.sv
// Transmit path: at each slot start decides whether the slot is served,
// pops the selected channel FIFO and shifts the word out MSB first.
// Assumes: FIFO read data is show-ahead; the word sits in the low bits.
module tdm_tx
    import tdm_pkg::*;
#(
    parameter int W      = 32,
    parameter int NSLOT  = 32,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              word_start,
    input  logic              active,
    input  logic [SLOT_W-1:0] next_slot,
    input  logic              two_chan,
    input  logic [NSLOT-1:0]  slot_mask,
    input  logic [BIT_W-1:0]  wlen_m1,
    input  logic [1:0]        fifo_empty,
    input  logic [1:0][W-1:0] fifo_rdata,
    output logic [1:0]        fifo_pop,
    output logic              sd_out,
    output logic              sd_out_en,
    output logic              underflow
);
    tdm_ch_e          ch_q, eff_ch;
    logic             use_ch, slot_on, serve, have_word;
    logic [W-1:0]     sh_q;
    logic             en_q, uf_q;
    logic [BIT_W-1:0] shamt;

    assign slot_on   = slot_mask[next_slot];
    assign eff_ch    = (next_slot == '0) ? CH_ZERO : ch_q;
    assign use_ch    = two_chan && (eff_ch == CH_ONE);
    assign serve     = word_start && active && slot_on;
    assign have_word = !fifo_empty[use_ch];
    assign shamt     = BIT_W'(W - 1) - wlen_m1;

    // Pop strobe toward the selected channel FIFO.
    always_comb begin
        fifo_pop = '0;
        if (serve && have_word) begin
            fifo_pop[use_ch] = 1'b1;
        end
    end

    // Word load at slot start, left shift on other bit periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            en_q <= 1'b0;
            uf_q <= 1'b0;
        end else if (word_start) begin
            if (serve && have_word) begin
                sh_q <= fifo_rdata[use_ch] << shamt;
                en_q <= 1'b1;
            end else begin
                sh_q <= '0;
                en_q <= 1'b0;
            end
            if (serve && !have_word) begin
                uf_q <= 1'b1;
            end
        end else if (bit_en) begin
            sh_q <= sh_q << 1;
        end
    end

    // Channel alternation, restarted at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= CH_ZERO;
        end else if (word_start && active) begin
            ch_q <= tdm_next_ch(eff_ch, slot_on);
        end
    end

    assign sd_out    = sh_q[W-1];
    assign sd_out_en = en_q;
    assign underflow = uf_q;

    assert_idle_slot_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_out_en |-> !sd_out);

    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    assert_empty_slot_underflows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && fifo_empty[use_ch]) |=> (underflow && !sd_out_en));

endmodule

// File: rtl/tdm_rx.sv
// Receive path: shifts sd_in in every bit period and, at the end of a
// served slot, pushes the right-justified word into the selected FIFO.
// Assumes: a word counts only if the port was locked for the whole slot.
module tdm_rx
    import tdm_pkg::*;
#(
    parameter int W      = 32,
    parameter int NSLOT  = 32,
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              word_start,
    input  logic              locked,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic              two_chan,
    input  logic [NSLOT-1:0]  slot_mask,
    input  logic [BIT_W-1:0]  wlen_m1,
    input  logic              sd_in,
    input  logic [1:0]        fifo_full,
    output logic [1:0]        fifo_push,
    output logic [W-1:0]      word,
    output logic              overflow
);
    tdm_ch_e          ch_q, eff_ch;
    logic             use_ch, slot_on, serve;
    logic [W-2:0]     sh_q;
    logic [W-1:0]     word_raw, keep;
    logic             of_q;

    assign word_raw = {sh_q, sd_in};
    assign keep     = {W{1'b1}} >> (BIT_W'(W - 1) - wlen_m1);
    assign word     = word_raw & keep;
    assign slot_on  = slot_mask[cur_slot];
    assign eff_ch   = (cur_slot == '0) ? CH_ZERO : ch_q;
    assign use_ch   = two_chan && (eff_ch == CH_ONE);
    assign serve    = word_start && locked && slot_on;

    // Push strobe toward the selected channel FIFO.
    always_comb begin
        fifo_push = '0;
        if (serve && !fifo_full[use_ch]) begin
            fifo_push[use_ch] = 1'b1;
        end
    end

    // Serial capture, one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (bit_en) begin
            sh_q <= word_raw[W-2:0];
        end
    end

    // Sticky overflow and channel alternation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            of_q <= 1'b0;
            ch_q <= CH_ZERO;
        end else if (word_start && locked) begin
            if (serve && fifo_full[use_ch]) begin
                of_q <= 1'b1;
            end
            ch_q <= tdm_next_ch(eff_ch, slot_on);
        end
    end

    assign overflow = of_q;

    assert_no_overflow_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && fifo_full[use_ch]) |=> overflow);

    assert_masked_slot_no_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_start && !slot_on) |-> (fifo_push == 2'b00));

endmodule

// File: rtl/tdm_port.sv
// TDM network serial port top: frame timing, transmit and receive paths,
// and one transmit plus one receive FIFO per channel.
// Assumes: configuration inputs only change while rst_n is low.
module tdm_port #(
    parameter int WORD_W     = 32,
    parameter int NUM_SLOTS  = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bit_en,
    input  logic                                master_mode,
    input  logic                                two_chan,
    input  logic [$clog2(NUM_SLOTS)-1:0]        slots_m1,
    input  logic [$clog2(WORD_W)-1:0]           wlen_m1,
    input  logic [NUM_SLOTS-1:0]                tx_slot_en,
    input  logic [NUM_SLOTS-1:0]                rx_slot_en,
    input  logic                                fs_in,
    output logic                                fs_out,
    input  logic                                sd_in,
    output logic                                sd_out,
    output logic                                sd_out_en,
    input  logic [1:0]                          tx_push,
    input  logic [2*WORD_W-1:0]                 tx_wdata,
    output logic [1:0]                          tx_full,
    input  logic [1:0]                          rx_pop,
    output logic [2*WORD_W-1:0]                 rx_rdata,
    output logic [1:0]                          rx_empty,
    output logic                                tx_underflow,
    output logic                                rx_overflow
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int NCH    = 2;

    logic              word_start, locked, lock_next;
    logic [SLOT_W-1:0] cur_slot, next_slot;
    logic [NCH-1:0]    tx_pop, tx_empty, rx_push, rx_full;
    logic [NCH-1:0][WORD_W-1:0] tx_rd;
    logic [WORD_W-1:0] rx_word;

    tdm_timing #(.SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_timing (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .master_mode(master_mode),
        .fs_in(fs_in), .slots_m1(slots_m1), .wlen_m1(wlen_m1), .fs_out(fs_out),
        .word_start(word_start), .cur_slot(cur_slot), .next_slot(next_slot),
        .locked(locked), .lock_next(lock_next)
    );

    tdm_tx #(.W(WORD_W), .NSLOT(NUM_SLOTS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_start(word_start),
        .active(lock_next), .next_slot(next_slot), .two_chan(two_chan),
        .slot_mask(tx_slot_en), .wlen_m1(wlen_m1), .fifo_empty(tx_empty),
        .fifo_rdata(tx_rd), .fifo_pop(tx_pop), .sd_out(sd_out),
        .sd_out_en(sd_out_en), .underflow(tx_underflow)
    );

    tdm_rx #(.W(WORD_W), .NSLOT(NUM_SLOTS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_start(word_start),
        .locked(locked), .cur_slot(cur_slot), .two_chan(two_chan),
        .slot_mask(rx_slot_en), .wlen_m1(wlen_m1), .sd_in(sd_in),
        .fifo_full(rx_full), .fifo_push(rx_push), .word(rx_word),
        .overflow(rx_overflow)
    );

    // One transmit and one receive FIFO per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
            .clk(clk), .rst_n(rst_n), .push(tx_push[c]),
            .wdata(tx_wdata[c*WORD_W +: WORD_W]), .pop(tx_pop[c]),
            .rdata(tx_rd[c]), .full(tx_full[c]), .empty(tx_empty[c])
        );
        tdm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
            .clk(clk), .rst_n(rst_n), .push(rx_push[c]), .wdata(rx_word),
            .pop(rx_pop[c]), .rdata(rx_rdata[c*WORD_W +: WORD_W]),
            .full(rx_full[c]), .empty(rx_empty[c])
        );
    end

    assert_single_channel_only_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !two_chan |-> (!tx_pop[1] && !rx_push[1]));

endmodule

// File: tb/test_tdm_port.sv
// Self-checking bench: a behavioural model using queues and integers,
// compared with the outputs on every clock.
module test_tdm_port;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic        clk = 1'b0;
    logic        rst_n, bit_en, master_mode, two_chan, fs_in, sd_in;
    logic [4:0]  slots_m1, wlen_m1;
    logic [31:0] tx_slot_en, rx_slot_en;
    logic [1:0]  tx_push, rx_pop, tx_full, rx_empty;
    logic [63:0] tx_wdata, rx_rdata;
    logic        fs_out, sd_out, sd_out_en, tx_underflow, rx_overflow;

    int n_chk = 0;
    int n_fail = 0;

    // Model state.
    int          m_bit, m_slot, m_txch, m_rxch;
    bit          m_locked, m_txen, m_uf, m_of;
    logic [31:0] m_txword;
    logic [63:0] m_acc;
    logic [31:0] tq0[$], tq1[$], rq0[$], rq1[$];

    tdm_port i_tdm_port (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .master_mode(master_mode),
        .two_chan(two_chan), .slots_m1(slots_m1), .wlen_m1(wlen_m1),
        .tx_slot_en(tx_slot_en), .rx_slot_en(rx_slot_en), .fs_in(fs_in),
        .fs_out(fs_out), .sd_in(sd_in), .sd_out(sd_out), .sd_out_en(sd_out_en),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int tsize(input int c);
        return (c == 0) ? tq0.size() : tq1.size();
    endfunction

    function automatic int rsize(input int c);
        return (c == 0) ? rq0.size() : rq1.size();
    endfunction

    // Predict the state after the next rising edge from the inputs now applied.
    task automatic model_step();
        int ts[2], rs[2];
        int wl, ns, eff, c;
        bit sync, wend, en;
        if (!rst_n) begin
            m_bit = int'(wlen_m1); m_slot = int'(slots_m1);
            m_locked = 0; m_txen = 0; m_uf = 0; m_of = 0;
            m_txword = '0; m_acc = '0; m_txch = 0; m_rxch = 0;
            tq0.delete(); tq1.delete(); rq0.delete(); rq1.delete();
        end else begin
            for (int k = 0; k < 2; k++) begin
                ts[k] = tsize(k);
                rs[k] = rsize(k);
            end
            wl = int'(wlen_m1) + 1;
            ns = int'(slots_m1) + 1;
            if (bit_en) begin
                sync = master_mode ? (m_bit == wl - 1 && m_slot == ns - 1) : fs_in;
                wend = sync || (m_bit == wl - 1);
                m_acc = ((m_acc << 1) | 64'(sd_in)) & ((64'd1 << wl) - 64'd1);
                if (wend && m_locked) begin
                    en  = rx_slot_en[m_slot];
                    eff = (m_slot == 0) ? 0 : m_rxch;
                    c   = two_chan ? eff : 0;
                    if (en) begin
                        if (rs[c] == DEPTH) m_of = 1;
                        else if (c == 0) rq0.push_back(m_acc[31:0]);
                        else rq1.push_back(m_acc[31:0]);
                    end
                    m_rxch = en ? 1 - eff : eff;
                end
                if (sync) begin
                    m_bit = 0; m_slot = 0; m_locked = 1;
                end else if (m_bit == wl - 1) begin
                    m_bit = 0; m_slot = (m_slot == ns - 1) ? 0 : m_slot + 1;
                end else begin
                    m_bit++;
                end
                if (wend) begin
                    m_txen = 0; m_txword = '0;
                    if (m_locked) begin
                        en  = tx_slot_en[m_slot];
                        eff = (m_slot == 0) ? 0 : m_txch;
                        c   = two_chan ? eff : 0;
                        if (en && ts[c] != 0) begin
                            m_txword = (c == 0) ? tq0.pop_front() : tq1.pop_front();
                            m_txen = 1;
                        end else if (en) begin
                            m_uf = 1;
                        end
                        m_txch = en ? 1 - eff : eff;
                    end
                end
            end
            for (int k = 0; k < 2; k++) begin
                if (tx_push[k] && ts[k] < DEPTH) begin
                    if (k == 0) tq0.push_back(tx_wdata[31:0]);
                    else tq1.push_back(tx_wdata[63:32]);
                end
                if (rx_pop[k] && rs[k] > 0) begin
                    if (k == 0) void'(rq0.pop_front());
                    else void'(rq1.pop_front());
                end
            end
        end
    endtask

    task automatic compare();
        int wl, ns;
        logic exp_sd;
        wl = int'(wlen_m1) + 1;
        ns = int'(slots_m1) + 1;
        exp_sd = m_txen ? m_txword[wl - 1 - m_bit] : 1'b0;
        chk("R1", "fs_out", 64'(fs_out),
            64'(master_mode && m_bit == wl - 1 && m_slot == ns - 1));
        chk("R3", "sd_out", 64'(sd_out), 64'(exp_sd));
        chk("R4", "sd_out_en", 64'(sd_out_en), 64'(m_txen));
        chk("R7", "tx_underflow", 64'(tx_underflow), 64'(m_uf));
        chk("R8", "rx_overflow", 64'(rx_overflow), 64'(m_of));
        chk("R9", "tx_full", 64'(tx_full), 64'({tq1.size() == DEPTH, tq0.size() == DEPTH}));
        chk("R9", "rx_empty0", 64'(rx_empty[0]), 64'(rq0.size() == 0));
        chk("R6", "rx_empty1", 64'(rx_empty[1]), 64'(rq1.size() == 0));
        if (rq0.size() > 0) chk("R5", "rx_rdata0", 64'(rx_rdata[31:0]), 64'(rq0[0]));
        if (rq1.size() > 0) chk("R6", "rx_rdata1", 64'(rx_rdata[63:32]), 64'(rq1[0]));
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run_phase(input logic mst, input logic two, input logic [4:0] sm1,
                             input logic [4:0] wm1, input logic [31:0] txm,
                             input logic [31:0] rxm, input int div, input int ncyc,
                             input int pushpct, input int poppct, input bit race);
        int flen, ext_pos;
        bit seen_sync, sync_now;
        master_mode = mst; two_chan = two; slots_m1 = sm1; wlen_m1 = wm1;
        tx_slot_en = txm; rx_slot_en = rxm;
        rst_n = 1'b0; bit_en = 1'b0; fs_in = 1'b0; sd_in = 1'b0;
        tx_push = '0; rx_pop = '0; tx_wdata = '0;
        for (int i = 0; i < 3; i++) cycle();
        // R10: reset state seen at the ports.
        chk("R10", "sd_out_en after reset", 64'(sd_out_en), 64'(0));
        chk("R10", "flags after reset", 64'({tx_underflow, rx_overflow}), 64'(0));
        chk("R10", "rx_empty after reset", 64'(rx_empty), 64'(2'b11));
        chk("R10", "tx_full after reset", 64'(tx_full), 64'(0));
        rst_n = 1'b1;
        flen = (int'(wm1) + 1) * (int'(sm1) + 1);
        ext_pos = 3;
        seen_sync = 0;
        for (int i = 0; i < ncyc; i++) begin
            bit_en = ((i % div) == 0);
            sd_in = 1'($urandom);
            fs_in = !mst && (ext_pos == flen - 1);
            sync_now = bit_en && fs_in;
            if (bit_en) ext_pos = (ext_pos + 1) % flen;
            tx_wdata = {$urandom, $urandom};
            for (int k = 0; k < 2; k++) begin
                tx_push[k] = (int'($urandom % 100) < pushpct);
                rx_pop[k]  = (int'($urandom % 100) < poppct);
            end
            if (race) begin
                tx_push[0] = bit_en && (m_bit == int'(wm1)) && (tq0.size() == 0);
            end
            cycle();
            if (!mst && !seen_sync && !sync_now) begin
                chk("R2", "sd_out_en before first sync", 64'(sd_out_en), 64'(0));
                chk("R2", "no rx word before first sync", 64'(rx_empty), 64'(2'b11));
            end
            seen_sync = seen_sync || sync_now;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 R3 R4 R5: master, single channel, 4 slots of 8 bits, sparse masks.
        run_phase(1'b1, 1'b0, 5'd3, 5'd7, 32'b1011, 32'b0110, 2, 700, 30, 50, 1'b0);
        // R6: master, two channels, 5 slots of 5 bits.
        run_phase(1'b1, 1'b1, 5'd4, 5'd4, 32'b11011, 32'b10111, 1, 700, 40, 40, 1'b0);
        // R2 R6: slave, two channels, minimum 2 slots of 3 bits.
        run_phase(1'b0, 1'b1, 5'd1, 5'd2, 32'b11, 32'b11, 3, 700, 40, 40, 1'b0);
        // R7 R8: push lands on an empty slot start; rare pops against a full rx FIFO.
        run_phase(1'b1, 1'b0, 5'd2, 5'd3, 32'b111, 32'b111, 1, 500, 0, 10, 1'b1);
        // R1 R3 R5: largest frame, 32 slots of 32 bits.
        run_phase(1'b1, 1'b0, 5'd31, 5'd31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 2300, 50, 50, 1'b0);
        // R4 R5: slave with every slot masked off in both directions.
        run_phase(1'b0, 1'b0, 5'd2, 5'd4, 32'h0, 32'h0, 2, 300, 60, 0, 1'b0);
        chk("R4", "no tx underflow with all slots masked", 64'(tx_underflow), 64'(0));
        chk("R5", "nothing received with all slots masked", 64'(rx_empty), 64'(2'b11));
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule